// File: doc/BRIEF.md
# Quadrature NCO Single-Sideband Phasing Modulator

This block forms a single-sideband signal entirely in the digital domain by the phasing method. One 32-bit phase accumulator advances by a programmable tuning word on every clock. Its top twelve bits address a single quarter-wave amplitude table, which is read at two addresses: the truncated phase itself gives the sine carrier, and the same phase advanced by a quarter turn gives the cosine carrier. The two carriers therefore stay exactly 90 degrees apart with nothing to trim. The carrier frequency is tuning word × clock / 2^32. A new tuning word takes effect on the next clock edge with no settling time.

Each valid baseband pair (I, Q) is multiplied by the carriers captured on the same edge. The products are added or subtracted according to a sideband-select input, and the sum is rounded and saturated to a signed 16-bit output sample. A result leaves the block a fixed three cycles after its input, with its own valid strobe. The Hilbert-transformed audio that produces Q, any filtering and the converter are outside the block.

Top module: `ssb_phasing_mod`

## Requirements
- R1: After reset, out_valid is 0 and out_sample is 0, and the phase accumulator holds 0, so the first captured sample sees phase 0.
- R2: On every clock edge the phase advances by the tuning word present at that edge, modulo 2^32. A sample captured on an edge uses the phase held before that edge. A tuning-word change never resets the phase, so the phase stays continuous.
- R3: The sine table address is phase[31:20] and the cosine address is that value plus 1024, modulo 4096. The carrier value at address a is round(32767 × sin(2πa/4096)), rounded away from zero, so address 0 gives sine 0 and cosine 32767.
- R4: When lower_sb is 0 (upper sideband), the sum is I·cos − Q·sin.
- R5: When lower_sb is 1 (lower sideband), the sum is I·cos + Q·sin.
- R6: The output is the sum plus 2^14, shifted right arithmetically by 15 bits.
- R7: A scaled value above 32767 gives 32767, and one below −32768 gives −32768.
- R8: out_valid is in_valid delayed by exactly 3 clock cycles. Each output belongs to the inputs and the phase of its capture edge, in order, including back-to-back samples.
- R9: While no result is emerging, out_sample keeps its last value, whatever I, Q, lower_sb and the tuning word do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ftw | input | 32 | Tuning word added to the phase each clock |
| lower_sb | input | 1 | 1 selects lower sideband, 0 selects upper sideband |
| in_valid | input | 1 | I and Q samples are valid this cycle |
| in_i | input | 16 | Signed in-phase baseband sample |
| in_q | input | 16 | Signed quadrature baseband sample |
| out_valid | output | 1 | out_sample carries a new result |
| out_sample | output | 16 | Signed single-sideband output sample |

## Verification
A tuning-word change and a sample capture can land on the same edge. In that case the captured sample must use the old phase, and the new step must apply from the next edge on. The bench provokes this by changing the tuning word with every sample of a back-to-back burst, including values that wrap the accumulator. It judges each output against a phase model that advances on the edge after the word appears. Saturation and a sideband flip can also fall on the same cycle. The bench places the phase where the sine and cosine magnitudes are equal, so that one sideband overflows while the other cancels to zero.

// File: rtl/ssb_mod_pkg.sv
package ssb_mod_pkg;
  localparam int PHASE_W = 32;
  localparam int LUT_ADDR_W = 12;
  localparam int SAMPLE_W = 16;
  localparam int CARRIER_W = 16;

  // Magnitude of one quarter-wave entry k of qtr steps, scaled to peak.
  function automatic int quarter_amp(input int k, input int qtr, input int peak);
    real ang;
    real v;
    ang = 1.5707963267948966 * real'(k) / real'(qtr);
    v = $sin(ang) * real'(peak);
    return $rtoi(v + 0.5);
  endfunction
endpackage

// File: rtl/phase_acc.sv
module phase_acc #(
  parameter int PW = ssb_mod_pkg::PHASE_W,
  parameter int AW = ssb_mod_pkg::LUT_ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] ftw,
  output logic [AW-1:0] idx
);
  logic [PW-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_q + ftw;
  end

  assign idx = phase_q[PW-1 -: AW];
endmodule

// File: rtl/quad_sine_lut.sv
module quad_sine_lut #(
  parameter int AW = ssb_mod_pkg::LUT_ADDR_W,
  parameter int CW = ssb_mod_pkg::CARRIER_W
) (
  input  logic [AW-1:0]        sin_idx,
  output logic signed [CW-1:0] sin_val,
  output logic signed [CW-1:0] cos_val
);
  localparam int QTR  = 1 << (AW - 2);
  localparam int PEAK = (1 << (CW - 1)) - 1;

  // One shared quarter table including the end point at QTR.
  logic [CW-1:0] tab [QTR+1];
  for (genvar k = 0; k <= QTR; k++) begin : g_tab
    assign tab[k] = CW'(ssb_mod_pkg::quarter_amp(k, QTR, PEAK));
  end

  logic [AW-1:0]        port_idx [2];
  logic signed [CW-1:0] port_val [2];
  assign port_idx[0] = sin_idx;
  assign port_idx[1] = sin_idx + AW'(QTR);

  for (genvar p = 0; p < 2; p++) begin : g_port
    logic [1:0]    quad;
    logic [AW-2:0] fine;
    logic [AW-2:0] mir;
    logic [CW-1:0] mag;
    assign quad = port_idx[p][AW-1 -: 2];
    assign fine = {1'b0, port_idx[p][AW-3:0]};
    assign mir  = quad[0] ? ((AW-1)'(QTR) - fine) : fine;
    assign mag  = tab[mir];
    assign port_val[p] = quad[1] ? -$signed(mag) : $signed(mag);
  end

  assign sin_val = port_val[0];
  assign cos_val = port_val[1];
endmodule

// File: rtl/ssb_mixer.sv
module ssb_mixer #(
  parameter int SW = ssb_mod_pkg::SAMPLE_W,
  parameter int CW = ssb_mod_pkg::CARRIER_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [SW-1:0] in_i,
  input  logic signed [SW-1:0] in_q,
  input  logic                 lower_sb,
  input  logic signed [CW-1:0] cos_val,
  input  logic signed [CW-1:0] sin_val,
  output logic                 s2_valid,
  output logic                 sat_hi,
  output logic                 sat_lo,
  output logic                 out_valid,
  output logic signed [SW-1:0] out_sample
);
  localparam int PROD_W = SW + CW;
  localparam int SUM_W  = PROD_W + 1;
  localparam int SHIFT  = CW - 1;
  localparam logic signed [SUM_W:0] BIAS =
    {{(SUM_W + 1 - SHIFT){1'b0}}, 1'b1, {(SHIFT - 1){1'b0}}};
  localparam logic signed [SUM_W:0] LIM_HI = (SUM_W+1)'((1 << (SW - 1)) - 1);
  localparam logic signed [SUM_W:0] LIM_LO = (SUM_W+1)'(-(1 << (SW - 1)));

  function automatic logic signed [SUM_W:0] scale_round(input logic signed [SUM_W-1:0] s);
    logic signed [SUM_W:0] b;
    b = {s[SUM_W-1], s} + BIAS;
    return b >>> SHIFT;
  endfunction

  function automatic logic signed [SUM_W-1:0] side_sum(
    input logic signed [PROD_W-1:0] pi,
    input logic signed [PROD_W-1:0] pq,
    input logic                     lower);
    logic signed [SUM_W-1:0] a;
    logic signed [SUM_W-1:0] b;
    a = {pi[PROD_W-1], pi};
    b = {pq[PROD_W-1], pq};
    return lower ? (a + b) : (a - b);
  endfunction

  logic                  s1_valid;
  logic signed [SW-1:0]  s1_i, s1_q;
  logic signed [CW-1:0]  s1_cos, s1_sin;
  logic                  s1_lower;
  logic signed [PROD_W-1:0] prod_i, prod_q;
  logic                  s2_lower;
  logic signed [SUM_W-1:0] sum_w;
  logic signed [SUM_W:0]   scaled;
  logic signed [SW-1:0]    sat_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_i <= '0; s1_q <= '0; s1_cos <= '0; s1_sin <= '0; s1_lower <= 1'b0;
      s2_valid <= 1'b0;
      prod_i <= '0; prod_q <= '0; s2_lower <= 1'b0;
      out_valid <= 1'b0;
      out_sample <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_i <= in_i;
        s1_q <= in_q;
        s1_cos <= cos_val;
        s1_sin <= sin_val;
        s1_lower <= lower_sb;
      end
      s2_valid <= s1_valid;
      if (s1_valid) begin
        prod_i <= s1_i * s1_cos;
        prod_q <= s1_q * s1_sin;
        s2_lower <= s1_lower;
      end
      out_valid <= s2_valid;
      if (s2_valid) out_sample <= sat_val;
    end
  end

  always_comb begin
    sum_w  = side_sum(prod_i, prod_q, s2_lower);
    scaled = scale_round(sum_w);
    sat_hi = scaled > LIM_HI;
    sat_lo = scaled < LIM_LO;
    if (sat_hi)      sat_val = SW'(LIM_HI);
    else if (sat_lo) sat_val = SW'(LIM_LO);
    else             sat_val = scaled[SW-1:0];
  end
endmodule

// File: rtl/ssb_phasing_mod.sv
module ssb_phasing_mod #(
  parameter int PW = ssb_mod_pkg::PHASE_W,
  parameter int AW = ssb_mod_pkg::LUT_ADDR_W,
  parameter int SW = ssb_mod_pkg::SAMPLE_W,
  parameter int CW = ssb_mod_pkg::CARRIER_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PW-1:0]        ftw,
  input  logic                 lower_sb,
  input  logic                 in_valid,
  input  logic signed [SW-1:0] in_i,
  input  logic signed [SW-1:0] in_q,
  output logic                 out_valid,
  output logic signed [SW-1:0] out_sample
);
  logic [AW-1:0]        sin_idx;
  logic signed [CW-1:0] sin_val;
  logic signed [CW-1:0] cos_val;
  logic                 s2_valid;
  logic                 sat_hi;
  logic                 sat_lo;

  phase_acc #(.PW(PW), .AW(AW)) u_acc (
    .clk(clk), .rst_n(rst_n), .ftw(ftw), .idx(sin_idx)
  );

  quad_sine_lut #(.AW(AW), .CW(CW)) u_lut (
    .sin_idx(sin_idx), .sin_val(sin_val), .cos_val(cos_val)
  );

  ssb_mixer #(.SW(SW), .CW(CW)) u_mix (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .lower_sb(lower_sb), .cos_val(cos_val), .sin_val(sin_val),
    .s2_valid(s2_valid), .sat_hi(sat_hi), .sat_lo(sat_lo),
    .out_valid(out_valid), .out_sample(out_sample)
  );
endmodule

// File: rtl/ssb_phasing_mod_chk.sv
module ssb_phasing_mod_chk #(
  parameter int PW = 32,
  parameter int AW = 12,
  parameter int SW = 16,
  parameter int CW = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [PW-1:0]        ftw,
  input logic [PW-1:0]        phase,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic signed [SW-1:0] out_sample,
  input logic [AW-1:0]        sin_idx,
  input logic signed [CW-1:0] sin_val,
  input logic signed [CW-1:0] cos_val,
  input logic                 s2_valid,
  input logic                 sat_hi,
  input logic                 sat_lo
);
  localparam logic signed [SW-1:0] OMAX = {1'b0, {(SW-1){1'b1}}};
  localparam logic signed [SW-1:0] OMIN = {1'b1, {(SW-1){1'b0}}};
  localparam logic signed [CW-1:0] PEAK = {1'b0, {(CW-1){1'b1}}};

  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd0) |-> (phase == $past(phase) + $past(ftw)));

  a_r3_quadrature_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sin_idx == '0) |-> (sin_val == '0 && cos_val == PEAK));

  a_r7_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && sat_hi) |=> (out_sample == OMAX));

  a_r7_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && sat_lo) |=> (out_sample == OMIN));

  a_r8_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd0 && !$past(s2_valid)) |-> $stable(out_sample));
endmodule

bind ssb_phasing_mod ssb_phasing_mod_chk #(.PW(PW), .AW(AW), .SW(SW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ftw(ftw), .phase(u_acc.phase_q),
  .in_valid(in_valid), .out_valid(out_valid), .out_sample(out_sample),
  .sin_idx(sin_idx), .sin_val(sin_val), .cos_val(cos_val),
  .s2_valid(s2_valid), .sat_hi(sat_hi), .sat_lo(sat_lo)
);

// File: tb/sim_ssb_phasing_mod.sv
module sim_ssb_phasing_mod;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] ftw = '0;
  logic lower_sb = 1'b0;
  logic in_valid = 1'b0;
  logic signed [15:0] in_i = '0;
  logic signed [15:0] in_q = '0;
  logic out_valid;
  logic signed [15:0] out_sample;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ssb_phasing_mod u0 (
    .clk(clk), .rst_n(rst_n), .ftw(ftw), .lower_sb(lower_sb),
    .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_sample(out_sample)
  );

  // Phase model: advances by the word present at each edge.
  logic [31:0] mphase;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) mphase <= '0;
    else        mphase <= mphase + ftw;
  end

  function automatic longint ref_amp(input int a);
    real r;
    r = 32767.0 * $sin(6.283185307179586 * real'(a) / 4096.0);
    if (r >= 0.0) return longint'($rtoi(r + 0.5));
    return -longint'($rtoi(-r + 0.5));
  endfunction

  function automatic logic signed [15:0] ref_out(input logic [31:0] ph,
      input logic signed [15:0] i, input logic signed [15:0] q, input logic lsb);
    int a;
    longint c, s, acc, y;
    a = int'(ph[31:20]);
    s = ref_amp(a);
    c = ref_amp((a + 1024) % 4096);
    acc = lsb ? (longint'(i) * c + longint'(q) * s) : (longint'(i) * c - longint'(q) * s);
    y = (acc + 16384) >>> 15;
    if (y > 32767) y = 32767;
    if (y < -32768) y = -32768;
    return 16'(y);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  logic signed [15:0] si [16];
  logic signed [15:0] sq [16];
  logic               sl [16];
  logic [31:0]        sf [16];

  // Drives n samples back to back and checks every cycle of the pipeline.
  task automatic stream(input int n, input string req);
    logic signed [15:0] ey [16];
    for (int k = 0; k < n + 4; k++) begin
      @(negedge clk);
      if (k >= 3 && k - 3 < n) begin
        chk(out_valid == 1'b1, "R8 out_valid high", longint'(out_valid), 1);
        chk(out_sample == ey[k-3], req, longint'(out_sample), longint'(ey[k-3]));
      end else begin
        chk(out_valid == 1'b0, "R8 out_valid low", longint'(out_valid), 0);
      end
      if (k < n) begin
        in_valid = 1'b1;
        in_i = si[k];
        in_q = sq[k];
        lower_sb = sl[k];
        ey[k] = ref_out(mphase, si[k], sq[k], sl[k]);
        ftw = sf[k];
      end else begin
        in_valid = 1'b0;
      end
    end
  endtask

  task automatic set_phase(input logic [31:0] target);
    @(negedge clk);
    ftw = target - mphase;
    @(negedge clk);
    ftw = '0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", longint'(out_valid), 0);
    chk(out_sample == 16'sd0, "R1 out_sample after reset", longint'(out_sample), 0);
    si[0] = 16'sd32767; sq[0] = 16'sd0; sl[0] = 1'b0; sf[0] = '0;
    stream(1, "R1 R3 first sample at phase zero");
  endtask

  task automatic t_carrier_cos;
    @(negedge clk);
    ftw = 32'h0123_4567;
    for (int k = 0; k < 10; k++) begin
      si[k] = (k == 9) ? -16'sd32768 : 16'sd32767;
      sq[k] = 16'sd0;
      sl[k] = k[0];
      sf[k] = 32'h0123_4567;
    end
    stream(10, "R2 R3 scaled cosine carrier");
  endtask

  task automatic t_sidebands;
    @(negedge clk);
    ftw = 32'h0765_4321;
    for (int k = 0; k < 12; k++) begin
      si[k] = 16'(12000 - 2100 * k);
      sq[k] = 16'(-9000 + 1700 * k);
      sl[k] = (k % 3) == 1;
      sf[k] = 32'h0765_4321;
    end
    stream(12, "R4 R5 sideband sum");
  endtask

  task automatic t_ftw_switch;
    for (int k = 0; k < 12; k++) begin
      si[k] = 16'sd20000;
      sq[k] = 16'(5000 * (k - 6));
      sl[k] = k[1];
      sf[k] = 32'hF000_0000 + 32'(k) * 32'h1357_9BDF;
    end
    stream(12, "R2 tuning change on sample edge");
  endtask

  task automatic t_saturate;
    set_phase(32'h2000_0000);
    si[0] = 16'sd32767;  sq[0] = 16'sd32767;  sl[0] = 1'b1; sf[0] = '0;
    si[1] = -16'sd32768; sq[1] = -16'sd32768; sl[1] = 1'b1; sf[1] = '0;
    si[2] = 16'sd32767;  sq[2] = 16'sd32767;  sl[2] = 1'b0; sf[2] = '0;
    si[3] = 16'sd32767;  sq[3] = -16'sd32767; sl[3] = 1'b0; sf[3] = '0;
    si[4] = -16'sd32768; sq[4] = 16'sd32767;  sl[4] = 1'b0; sf[4] = '0;
    stream(5, "R7 saturation at equal carriers");
    set_phase(32'h0000_0000);
    si[0] = 16'sd1;     sq[0] = 16'sd0; sl[0] = 1'b0; sf[0] = '0;
    si[1] = -16'sd1;    sq[1] = 16'sd0; sl[1] = 1'b0; sf[1] = '0;
    si[2] = 16'sd16384; sq[2] = 16'sd5; sl[2] = 1'b1; sf[2] = '0;
    si[3] = -16'sd3;    sq[3] = 16'sd7; sl[3] = 1'b0; sf[3] = '0;
    stream(4, "R6 round half up");
  endtask

  task automatic t_hold;
    logic signed [15:0] last;
    @(negedge clk);
    ftw = 32'h0ABC_DEF1;
    si[0] = 16'sd11111; sq[0] = -16'sd22222; sl[0] = 1'b0; sf[0] = 32'h0ABC_DEF1;
    stream(1, "R4 single sample before idle");
    last = out_sample;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      in_i = 16'(7777 * k);
      in_q = 16'(-3333 * k);
      lower_sb = k[0];
      ftw = 32'(k) * 32'h1111_1111;
      chk(out_valid == 1'b0, "R9 no valid while idle", longint'(out_valid), 0);
      chk(out_sample == last, "R9 output held while idle", longint'(out_sample), longint'(last));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_carrier_cos();
    t_sidebands();
    t_ftw_switch();
    t_saturate();
    t_hold();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule